// File: doc/BRIEF.md
# Low-power DDR power-up initialization sequencer

This block brings a low-power DDR (first generation) memory device from power-on to normal operation with no help from software. Once reset is released it enables the memory clock and issues a first NOP. It then waits out the power-up interval and issues a second NOP together with a request to the pad calibration logic. When calibration reports completion, it issues a precharge of all banks, two auto-refresh commands, an extended mode register load and a mode register load. Each command is separated from the previous one by the device's minimum spacing. At the end it raises a done flag and enables the refresh timer.

The extended mode register carries the partial array self-refresh, temperature-compensated self-refresh and drive strength fields. The mode register carries the burst code and the CAS latency. All of these come from static configuration inputs, which the system holds stable while the block runs. A configuration input selects between four-bank devices and small two-bank devices, which changes the bank address used for the extended mode load. The power-up wait is derived from the clock frequency and the required microseconds. The precharge, refresh and mode-load gaps are given in clock cycles.

Top module: `lpddr_init_seq`

## Requirements
- R1: While rst_ni is low, every output is 0. Asserting rst_ni low in the middle of the sequence restarts the sequence from the first step after release.
- R2: In the first clock cycle after reset release, a NOP (cmd_o=0) is issued and mem_clk_en_o goes high together with it. mem_clk_en_o stays high until the next reset.
- R3: The second NOP is issued exactly PWR_CYC = CLK_KHZ*PWR_US/1000 cycles after the first, with no command in between. cal_req_o is high for exactly that one cycle and at no other time.
- R4: No command is issued after the second NOP until cal_done_i is sampled high. The precharge-all (cmd_o=1) then follows in the next cycle, with ba_o=0 and only addr_o[10] set.
- R5: The first auto-refresh (cmd_o=2) comes TRP_CYC cycles after the precharge-all. The second auto-refresh comes TRFC_CYC cycles after the first.
- R6: The extended mode load (cmd_o=3) comes TRFC_CYC cycles after the second refresh. It uses ba_o=2'b10, or ba_o=2'b01 when cfg_two_bank_i is 1. Its address is {0, ds[2:0] at [7:5], tcsr[1:0] at [4:3], pasr[2:0] at [2:0]}.
- R7: The mode load (cmd_o=4) comes TMRD_CYC cycles after the extended mode load. It uses ba_o=0 and address {0, cas[2:0] at [6:4], 0 at [3], BURST_CODE at [2:0]}.
- R8: init_done_o and refresh_en_o rise TMRD_CYC cycles after the mode load and stay high. No command is issued after that.
- R9: cmd_valid_o marks each command cycle. Exactly seven commands are issued in the order NOP, NOP, precharge-all, refresh, refresh, extended mode load, mode load. In cycles without a command, cmd_o, ba_o and addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_done_i | input | 1 | Pad calibration complete |
| cfg_two_bank_i | input | 1 | 1 selects a two-bank device |
| cfg_cas_lat_i | input | 3 | CAS latency code for the mode register |
| cfg_tcsr_i | input | 2 | Temperature-compensated self-refresh code |
| cfg_pasr_i | input | 3 | Partial array self-refresh code |
| cfg_ds_i | input | 3 | Output drive strength code |
| mem_clk_en_o | output | 1 | Memory clock enable |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_o | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 refresh, 3 extended mode load, 4 mode load |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| cal_req_o | output | 1 | Single-cycle calibration request |
| init_done_o | output | 1 | Initialization finished |
| refresh_en_o | output | 1 | Enable for the periodic refresh timer |

## Verification
A wrong step register shows up at the ports as a command missing, repeated or out of order. The per-cycle reference comparison catches it in the first cycle where the command strobe or code differs. A wrong countdown value moves the next command by one or more cycles, and this is seen on the cycle the command should have appeared. A broken calibration handshake shows as a precharge issued before cal_done_i, or as a sequence that never finishes. The bench also checks the recorded command log for order, exact spacing and mode-register address fields across two device configurations.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_EMRS = 3'd3,
    CMD_MRS  = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    ST_NOP1, ST_NOP2, ST_PREA, ST_REF1, ST_REF2,
    ST_EMRS, ST_MRS, ST_FIN, ST_DONE
  } step_e;
endpackage

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lpddr_init_cmdgen.sv
module lpddr_init_cmdgen
  import lpddr_init_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter logic [2:0]  BURST_CODE = 3'b010
) (
  input  step_e              step_i,
  input  logic               two_bank_i,
  input  logic [2:0]         cas_i,
  input  logic [1:0]         tcsr_i,
  input  logic [2:0]         pasr_i,
  input  logic [2:0]         ds_i,
  output logic               has_cmd_o,
  output cmd_e               cmd_o,
  output logic [1:0]         ba_o,
  output logic [ADDR_W-1:0]  addr_o
);
  always_comb begin
    has_cmd_o = 1'b1;
    cmd_o     = CMD_NOP;
    ba_o      = 2'b00;
    addr_o    = '0;
    unique case (step_i)
      ST_NOP1, ST_NOP2: cmd_o = CMD_NOP;
      ST_PREA: begin
        cmd_o      = CMD_PREA;
        addr_o[10] = 1'b1;  // all-banks select
      end
      ST_REF1, ST_REF2: cmd_o = CMD_REF;
      ST_EMRS: begin
        cmd_o       = CMD_EMRS;
        ba_o        = two_bank_i ? 2'b01 : 2'b10;
        addr_o[2:0] = pasr_i;
        addr_o[4:3] = tcsr_i;
        addr_o[7:5] = ds_i;
      end
      ST_MRS: begin
        cmd_o       = CMD_MRS;
        addr_o[2:0] = BURST_CODE;
        addr_o[6:4] = cas_i;
      end
      default: has_cmd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int          CLK_KHZ    = 50000,
  parameter int          PWR_US     = 200,
  parameter int          TRP_CYC    = 3,
  parameter int          TRFC_CYC   = 9,
  parameter int          TMRD_CYC   = 2,
  parameter int          ADDR_W     = 13,
  parameter logic [2:0]  BURST_CODE = 3'b010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_done_i,
  input  logic              cfg_two_bank_i,
  input  logic [2:0]        cfg_cas_lat_i,
  input  logic [1:0]        cfg_tcsr_i,
  input  logic [2:0]        cfg_pasr_i,
  input  logic [2:0]        cfg_ds_i,
  output logic              mem_clk_en_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cal_req_o,
  output logic              init_done_o,
  output logic              refresh_en_o
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PWR_CYC = CLK_KHZ * PWR_US / 1000;
  localparam int MAX_GAP = max2(max2(PWR_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  step_e              step_q, step_d;
  logic               expired, fire, issue, has_cmd;
  logic [CNT_W-1:0]   gap_val;
  cmd_e               cmd_c;
  logic [1:0]         ba_c;
  logic [ADDR_W-1:0]  addr_c;
  logic               clk_en_q, done_q, valid_q, cal_q;
  logic [2:0]         cmd_q;
  logic [1:0]         ba_q;
  logic [ADDR_W-1:0]  addr_q;

  // a step acts once its gap has run out; precharge also needs calibration
  assign fire  = expired && (step_q != ST_DONE) && ((step_q != ST_PREA) || cal_done_i);
  assign issue = fire && has_cmd;

  always_comb begin
    step_d = step_q;
    if (fire) begin
      unique case (step_q)
        ST_NOP1: step_d = ST_NOP2;
        ST_NOP2: step_d = ST_PREA;
        ST_PREA: step_d = ST_REF1;
        ST_REF1: step_d = ST_REF2;
        ST_REF2: step_d = ST_EMRS;
        ST_EMRS: step_d = ST_MRS;
        ST_MRS:  step_d = ST_FIN;
        default: step_d = ST_DONE;
      endcase
    end
  end

  // cycles until the next step may act, minus one
  always_comb begin
    unique case (step_q)
      ST_NOP1:          gap_val = CNT_W'(PWR_CYC - 1);
      ST_PREA:          gap_val = CNT_W'(TRP_CYC - 1);
      ST_REF1, ST_REF2: gap_val = CNT_W'(TRFC_CYC - 1);
      ST_EMRS, ST_MRS:  gap_val = CNT_W'(TMRD_CYC - 1);
      default:          gap_val = '0;
    endcase
  end

  lpddr_init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire),
    .load_val_i (gap_val),
    .expired_o  (expired)
  );

  lpddr_init_cmdgen #(.ADDR_W(ADDR_W), .BURST_CODE(BURST_CODE)) i_cmdgen (
    .step_i     (step_q),
    .two_bank_i (cfg_two_bank_i),
    .cas_i      (cfg_cas_lat_i),
    .tcsr_i     (cfg_tcsr_i),
    .pasr_i     (cfg_pasr_i),
    .ds_i       (cfg_ds_i),
    .has_cmd_o  (has_cmd),
    .cmd_o      (cmd_c),
    .ba_o       (ba_c),
    .addr_o     (addr_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_NOP1;
      valid_q  <= 1'b0;
      cmd_q    <= '0;
      ba_q     <= '0;
      addr_q   <= '0;
      cal_q    <= 1'b0;
      clk_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      step_q   <= step_d;
      valid_q  <= issue;
      cmd_q    <= issue ? 3'(cmd_c) : 3'd0;
      ba_q     <= issue ? ba_c : 2'd0;
      addr_q   <= issue ? addr_c : '0;
      cal_q    <= fire && (step_q == ST_NOP2);
      clk_en_q <= clk_en_q | (fire && (step_q == ST_NOP1));
      done_q   <= done_q | (fire && (step_q == ST_FIN));
    end
  end

  assign mem_clk_en_o = clk_en_q;
  assign cmd_valid_o  = valid_q;
  assign cmd_o        = cmd_q;
  assign ba_o         = ba_q;
  assign addr_o       = addr_q;
  assign cal_req_o    = cal_q;
  assign init_done_o  = done_q;
  assign refresh_en_o = done_q;
endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk
  import lpddr_init_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cal_done_i,
  input logic       cfg_two_bank_i,
  input logic       mem_clk_en_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_o,
  input logic [1:0] ba_o,
  input logic       cal_req_o,
  input logic       init_done_o
);
  // R2
  clk_en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clk_en_o |=> mem_clk_en_o);
  // R2
  cmd_needs_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> mem_clk_en_o);
  // R3
  cal_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |=> !cal_req_o);
  // R3
  cal_req_with_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |-> (cmd_valid_o && cmd_o == 3'(CMD_NOP)));
  // R4
  prea_after_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'(CMD_PREA)) |-> $past(cal_done_i));
  // R6
  emrs_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'(CMD_EMRS)) |-> (ba_o == (cfg_two_bank_i ? 2'b01 : 2'b10)));
  // R7
  mrs_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'(CMD_MRS)) |-> (ba_o == 2'b00));
  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  // R8
  quiet_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> !cmd_valid_o);
  // R9
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_o == 3'd0 && ba_o == 2'd0));
endmodule

bind lpddr_init_seq lpddr_init_seq_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cal_done_i     (cal_done_i),
  .cfg_two_bank_i (cfg_two_bank_i),
  .mem_clk_en_o   (mem_clk_en_o),
  .cmd_valid_o    (cmd_valid_o),
  .cmd_o          (cmd_o),
  .ba_o           (ba_o),
  .cal_req_o      (cal_req_o),
  .init_done_o    (init_done_o)
);

// File: tb/test_lpddr_init_seq.sv
module test_lpddr_init_seq;
  localparam int         CLK_KHZ  = 50000;
  localparam int         PWR_US   = 200;
  localparam int         PWR_CYC  = CLK_KHZ * PWR_US / 1000;
  localparam int         TRP_CYC  = 3;
  localparam int         TRFC_CYC = 9;
  localparam int         TMRD_CYC = 2;
  localparam int         ADDR_W   = 13;
  localparam logic [2:0] BURST    = 3'b010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_done_i = 1'b0;
  logic cfg_two_bank_i = 1'b0;
  logic [2:0] cfg_cas_lat_i = '0;
  logic [1:0] cfg_tcsr_i = '0;
  logic [2:0] cfg_pasr_i = '0;
  logic [2:0] cfg_ds_i = '0;
  logic mem_clk_en_o, cmd_valid_o, cal_req_o, init_done_o, refresh_en_o;
  logic [2:0] cmd_o;
  logic [1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;

  always #10 clk = ~clk;

  lpddr_init_seq #(
    .CLK_KHZ(CLK_KHZ), .PWR_US(PWR_US), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .TMRD_CYC(TMRD_CYC), .ADDR_W(ADDR_W), .BURST_CODE(BURST)
  ) i_lpddr_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cal_done_i(cal_done_i),
    .cfg_two_bank_i(cfg_two_bank_i), .cfg_cas_lat_i(cfg_cas_lat_i),
    .cfg_tcsr_i(cfg_tcsr_i), .cfg_pasr_i(cfg_pasr_i), .cfg_ds_i(cfg_ds_i),
    .mem_clk_en_o(mem_clk_en_o), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .ba_o(ba_o), .addr_o(addr_o), .cal_req_o(cal_req_o),
    .init_done_o(init_done_o), .refresh_en_o(refresh_en_o)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit chk_en = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected command table, from the requirements
  function automatic logic [2:0] exp_cmd(input int i);
    case (i)
      0, 1: return 3'd0;
      2: return 3'd1;
      3, 4: return 3'd2;
      5: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] exp_ba(input int i);
    if (i == 5) return cfg_two_bank_i ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int i);
    logic [ADDR_W-1:0] a = '0;
    if (i == 2) a[10] = 1'b1;
    if (i == 5) begin a[2:0] = cfg_pasr_i; a[4:3] = cfg_tcsr_i; a[7:5] = cfg_ds_i; end
    if (i == 6) begin a[2:0] = BURST; a[6:4] = cfg_cas_lat_i; end
    return a;
  endfunction

  function automatic int exp_gap(input int i);
    case (i)
      0: return PWR_CYC;
      1: return 1;
      2: return TRP_CYC;
      3, 4: return TRFC_CYC;
      default: return TMRD_CYC;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference: what the outputs hold after each edge
  int m_idx, m_wait;
  logic e_valid, e_cal, e_clk, e_done;
  logic [2:0] e_cmd;
  logic [1:0] e_ba;
  logic [ADDR_W-1:0] e_addr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_idx = 0; m_wait = 0;
      e_valid = 0; e_cal = 0; e_clk = 0; e_done = 0;
      e_cmd = '0; e_ba = '0; e_addr = '0;
    end else begin
      e_valid = 0; e_cal = 0; e_cmd = '0; e_ba = '0; e_addr = '0;
      if (m_wait > 0) m_wait--;
      else if (m_idx < 7) begin
        if (!(m_idx == 2 && !cal_done_i)) begin
          e_valid = 1;
          e_cmd = exp_cmd(m_idx);
          e_ba = exp_ba(m_idx);
          e_addr = exp_addr(m_idx);
          if (m_idx == 0) e_clk = 1;
          if (m_idx == 1) e_cal = 1;
          m_wait = exp_gap(m_idx) - 1;
          m_idx++;
        end
      end else if (m_idx == 7) begin
        e_done = 1;
        m_idx = 8;
      end
    end
  end

  int log_t[$];
  logic [2:0] log_c[$];
  logic [1:0] log_b[$];
  logic [ADDR_W-1:0] log_a[$];
  int done_t = -1;

  always @(negedge clk) begin
    if (chk_en) begin
      check({cmd_valid_o, cmd_o, ba_o, addr_o} == {e_valid, e_cmd, e_ba, e_addr}, "R9 cmd bus",
            {cmd_valid_o, cmd_o, ba_o, addr_o}, {e_valid, e_cmd, e_ba, e_addr});
      check(cal_req_o == e_cal, "R3 cal_req", cal_req_o, e_cal);
      check(mem_clk_en_o == e_clk, "R2 clk_en", mem_clk_en_o, e_clk);
      check({init_done_o, refresh_en_o} == {e_done, e_done}, "R8 done/refresh",
            {init_done_o, refresh_en_o}, {e_done, e_done});
      if (cmd_valid_o) begin
        log_t.push_back(cyc); log_c.push_back(cmd_o);
        log_b.push_back(ba_o); log_a.push_back(addr_o);
      end
      if (init_done_o && done_t < 0) done_t = cyc;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    // r1_ reset state at the ports
    check({mem_clk_en_o, cmd_valid_o, cmd_o, ba_o, addr_o, cal_req_o, init_done_o, refresh_en_o} == '0,
          "R1 reset outputs",
          {mem_clk_en_o, cmd_valid_o, cmd_o, ba_o, addr_o, cal_req_o, init_done_o, refresh_en_o}, 0);
    log_t.delete(); log_c.delete(); log_b.delete(); log_a.delete();
    done_t = -1;
  endtask

  task automatic run(input bit two, input logic [2:0] cas, input logic [1:0] tcsr,
                     input logic [2:0] pasr, input logic [2:0] ds, input int cal_delay);
    cfg_two_bank_i = two; cfg_cas_lat_i = cas; cfg_tcsr_i = tcsr;
    cfg_pasr_i = pasr; cfg_ds_i = ds;
    cal_done_i = (cal_delay < 0);
    do_reset();
    chk_en = 1;
    rst_ni = 1'b1;
    while (!cal_req_o) step();
    if (cal_delay >= 0) begin
      repeat (cal_delay) step();
      // R4: nothing issued while calibration is outstanding
      check(log_c.size() == 2, "R4 wait for cal", log_c.size(), 2);
      cal_done_i = 1'b1;
      step();
      cal_done_i = 1'b0;
    end
    while (!init_done_o) step();
    repeat (10) step();
    check(log_c.size() == 7, "R8 command count", log_c.size(), 7);
    if (log_c.size() == 7) begin
      for (int i = 0; i < 7; i++)
        check(log_c[i] == exp_cmd(i), {tag_of(i), " order"}, log_c[i], exp_cmd(i));
      for (int i = 1; i < 7; i++) begin
        if (i != 2)
          check(log_t[i] - log_t[i-1] == exp_gap(i-1), {tag_of(i), " spacing"},
                log_t[i] - log_t[i-1], exp_gap(i-1));
        else
          check(log_t[i] - log_t[i-1] >= 1, "R4 spacing", log_t[i] - log_t[i-1], 1);
      end
      check(log_a[2] == exp_addr(2), "R4 prea addr", log_a[2], exp_addr(2));
      check(log_b[5] == (two ? 2'b01 : 2'b10), "R6 emrs bank", log_b[5], two ? 2'b01 : 2'b10);
      check(log_a[5] == exp_addr(5), "R6 emrs addr", log_a[5], exp_addr(5));
      check(log_b[6] == 2'b00, "R7 mrs bank", log_b[6], 0);
      check(log_a[6] == exp_addr(6), "R7 mrs addr", log_a[6], exp_addr(6));
      check(done_t - log_t[6] == TMRD_CYC, "R8 done delay", done_t - log_t[6], TMRD_CYC);
    end
    check(refresh_en_o == 1'b1, "R8 refresh enable", refresh_en_o, 1);
  endtask

  initial begin
    // four-bank device, calibration answers late
    run(1'b0, 3'd3, 2'd1, 3'd2, 3'd5, 6);
    // abort during the power-up wait
    do_reset();
    rst_ni = 1'b1;
    repeat (50) step();
    check(log_c.size() == 1, "R1 partial run", log_c.size(), 1);
    // two-bank device, calibration already done; reset lands mid-sequence
    run(1'b1, 3'd2, 2'd3, 3'd7, 3'd1, -1);
    chk_en = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule